// File: doc/BRIEF.md
# Over-temperature restart wakeup controller

This block is the digital side of a low-power temperature restart detector. Software arms it after it has found the die temperature outside its allowed range by other means. It then puts the core into its deepest stop mode. While the core is halted, the block watches the digital output of a coarse temperature comparator. When the temperature returns to the normal range, the block issues a one-cycle wakeup. If the core is in stop mode at that moment, the block also issues a one-cycle request for a full device reset, so leaving stop this way restarts the device from scratch rather than resuming code.

A polarity input chooses which limit is guarded: a cold limit or a hot limit. The comparator output is taken as 1 when the temperature is above the detector threshold. The comparator is asynchronous, so it passes through a synchronizer chain before any decision is made. A wakeup needs a real return into range: the block must first see an out-of-range level while armed, and then an in-range level.

Top module: `thermal_restart_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `wake_pulse` and `reset_req` are 0.
- R2: While `arm_en` is 0, no wakeup is produced, however `cmp_in` moves. A wakeup needs `arm_en` to be 1 on the cycle before it.
- R3: With `hot_guard` = 0 (cold guard), out of range means `cmp_in` = 0 and in range means `cmp_in` = 1. An armed low-to-high return raises `wake_pulse` on the third rising edge after `cmp_in` changes, with the default two synchronizer stages.
- R4: With `hot_guard` = 1 (hot guard), out of range means `cmp_in` = 1 and in range means `cmp_in` = 0. An armed high-to-low return raises `wake_pulse` with the same latency as R3.
- R5: If the level is already in range when the block is armed, no wakeup is produced until an out-of-range level has been seen while armed.
- R6: `wake_pulse` lasts exactly one cycle. A level that stays in range gives no further pulse until a new excursion out of range.
- R7: `reset_req` pulses in the same cycle as `wake_pulse`, but only if `stop_mode` was 1 at the clock edge that raised the wakeup. Otherwise it stays 0.
- R8: A change of `hot_guard` discards any pending excursion. No wakeup results from the polarity change itself.
- R9: Clearing `arm_en` discards a pending excursion. Re-arming while in range then gives no wakeup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the always-on domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_en | input | 1 | Arms the detector when 1 |
| hot_guard | input | 1 | 1 guards a hot limit, 0 guards a cold limit |
| stop_mode | input | 1 | 1 while the core is in deep stop |
| cmp_in | input | 1 | Asynchronous comparator output, 1 means above threshold |
| wake_pulse | output | 1 | One-cycle wakeup on return into range |
| reset_req | output | 1 | One-cycle full-reset request, only out of stop |

## Verification
The bench builds the block with its default of two synchronizer stages. This fixes the wakeup latency at three rising edges after the comparator moves, so the bench can check the exact cycle of the pulse, and not only its presence. With the short chain, the scenarios can walk through arming, excursion, return, disarm and polarity flips within a few dozen cycles each. Every scenario starts from a fresh reset, so no pending excursion carries over between scenarios.

// File: rtl/thermal_restart_ctl.sv
module thermal_restart_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_en,
  input  logic hot_guard,
  input  logic stop_mode,
  input  logic cmp_in,
  output logic wake_pulse,
  output logic reset_req
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pol_q;
  logic                   excursion_q;
  logic                   wake_q;
  logic                   rst_q;

  logic cmp_s, in_range, pol_same, fire;

  assign cmp_s    = sync_q[SYNC_STAGES-1];
  assign in_range = hot_guard ? ~cmp_s : cmp_s;
  assign pol_same = (hot_guard == pol_q);
  assign fire     = arm_en & pol_same & excursion_q & in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= '0;
      pol_q       <= 1'b0;
      excursion_q <= 1'b0;
      wake_q      <= 1'b0;
      rst_q       <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_in};
      pol_q  <= hot_guard;
      wake_q <= fire;
      rst_q  <= fire & stop_mode;
      if (!arm_en || !pol_same || fire)
        excursion_q <= 1'b0;
      else if (!in_range)
        excursion_q <= 1'b1;
    end
  end

  assign wake_pulse = wake_q;
  assign reset_req  = rst_q;

  // R2
  disarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_en |=> !wake_pulse);

  // R6
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R7
  rst_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (wake_pulse && $past(stop_mode)));

  // R7
  rst_when_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && $past(stop_mode)) |-> reset_req);

  // R8
  pol_flip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_guard != pol_q) |=> !wake_pulse);

endmodule

// File: tb/test_thermal_restart_ctl.sv
module test_thermal_restart_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_en = 1'b0, hot_guard = 1'b0, stop_mode = 1'b0, cmp_in = 1'b0;
  logic wake_pulse, reset_req;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  thermal_restart_ctl #(.SYNC_STAGES(2)) i_thermal_restart_ctl (
    .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .hot_guard(hot_guard),
    .stop_mode(stop_mode), .cmp_in(cmp_in),
    .wake_pulse(wake_pulse), .reset_req(reset_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic watch(input int n, output int wc, output int rc, output int first);
    wc = 0; rc = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (wake_pulse) begin
        wc++;
        if (first < 0) first = i;
      end
      if (reset_req) rc++;
    end
  endtask

  task automatic do_reset(input logic pol, input logic cmp);
    @(negedge clk);
    rst_n = 1'b0; arm_en = 1'b0; stop_mode = 1'b0;
    hot_guard = pol; cmp_in = cmp;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    int wc, rc, f;
    do_reset(1'b0, 1'b1);
    rst_n = 1'b0;
    arm_en = 1'b1;
    step(1);
    check("R1 wake in reset", int'(wake_pulse), 0);
    check("R1 reset_req in reset", int'(reset_req), 0);
    rst_n = 1'b1;
    watch(1, wc, rc, f);
    check("R1 wake after release", wc, 0);
    check("R1 reset_req after release", rc, 0);
  endtask

  task automatic t_disarmed();
    int wc, rc, f, tot;
    tot = 0;
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      cmp_in = ~cmp_in;
      watch(5, wc, rc, f);
      tot += wc;
    end
    check("R2 no wake while disarmed", tot, 0);
  endtask

  task automatic t_cold();
    int wc, rc, f;
    do_reset(1'b0, 1'b0);
    arm_en = 1'b1;
    step(5);
    cmp_in = 1'b1;
    watch(10, wc, rc, f);
    check("R3 cold return wake count", wc, 1);
    check("R3 cold return latency", f, 3);
  endtask

  task automatic t_hot();
    int wc, rc, f;
    do_reset(1'b1, 1'b1);
    arm_en = 1'b1;
    step(5);
    cmp_in = 1'b0;
    watch(10, wc, rc, f);
    check("R4 hot return wake count", wc, 1);
    check("R4 hot return latency", f, 3);
  endtask

  task automatic t_already_in();
    int wc, rc, f;
    do_reset(1'b0, 1'b1);
    step(4);
    arm_en = 1'b1;
    watch(12, wc, rc, f);
    check("R5 no wake when armed in range", wc, 0);
    cmp_in = 1'b0;
    step(5);
    cmp_in = 1'b1;
    watch(10, wc, rc, f);
    check("R5 wake after later excursion", wc, 1);
  endtask

  task automatic t_single();
    int wc, rc, f;
    do_reset(1'b1, 1'b1);
    arm_en = 1'b1;
    step(4);
    cmp_in = 1'b0;
    watch(20, wc, rc, f);
    check("R6 one pulse while staying in range", wc, 1);
    cmp_in = 1'b1;
    step(4);
    cmp_in = 1'b0;
    watch(10, wc, rc, f);
    check("R6 new excursion gives new pulse", wc, 1);
  endtask

  task automatic t_stop();
    int wc, rc, f;
    do_reset(1'b0, 1'b0);
    arm_en = 1'b1; stop_mode = 1'b1;
    step(4);
    cmp_in = 1'b1;
    watch(10, wc, rc, f);
    check("R7 wake in stop", wc, 1);
    check("R7 reset_req in stop", rc, 1);
    do_reset(1'b0, 1'b0);
    arm_en = 1'b1; stop_mode = 1'b0;
    step(4);
    cmp_in = 1'b1;
    watch(10, wc, rc, f);
    check("R7 wake outside stop", wc, 1);
    check("R7 no reset_req outside stop", rc, 0);
  endtask

  task automatic t_pol_flip();
    int wc, rc, f;
    do_reset(1'b0, 1'b0);
    arm_en = 1'b1;
    step(5);
    hot_guard = 1'b1;
    watch(12, wc, rc, f);
    check("R8 polarity flip gives no wake", wc, 0);
  endtask

  task automatic t_disarm_clears();
    int wc, rc, f;
    do_reset(1'b0, 1'b0);
    arm_en = 1'b1;
    step(5);
    arm_en = 1'b0;
    step(3);
    cmp_in = 1'b1;
    step(5);
    arm_en = 1'b1;
    watch(12, wc, rc, f);
    check("R9 disarm discards excursion", wc, 0);
  endtask

  initial begin
    t_reset();
    t_disarmed();
    t_cold();
    t_hot();
    t_already_in();
    t_single();
    t_stop();
    t_pol_flip();
    t_disarm_clears();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule